// File: doc/BRIEF.md
# OTG PHY Status Word and VBUS Change Detector

This block holds the status word of a USB On-The-Go PHY. A USB core drives it with level signals for VBUS-valid and session-active. The PHY side supplies line state, ID status, host-disconnect and VBUS-sense as read-only levels. Every input is registered once per clock. Software reads the result as one 32-bit word. When the registered VBUS-valid level differs from the stored value, the block emits a one-cycle request. An interrupt aggregator turns that request into the VBUS-sense-change source bit.

The two session bits are always stored as a complementary pair. A power-management enable masks the VBUS-valid bit in the word that is read back. The mask does not alter the stored bit or the change detection. Once reset is released, the word also reports that power and clock are good.

Top module: `otg_status_tracker`

## Requirements
- R1: While `rst_n` is low, `stat_rdata_o` reads 0 and `vbus_chg_o` is 0 whatever the inputs do. An ID status of 0 in the word means host mode.
- R2: One clock edge after sampling, the word carries the pass-through inputs at fixed positions: `line_state_i` at bits 1:0, `host_discon_i` at bit 2, `id_status_i` at bit 3 and `vbus_sense_i` at bit 4.
- R3: Bit 6 (session valid) equals the sampled `session_i` and bit 7 (session end) equals its inverse. Both bits update on the same edge, so they are complements from the first edge after reset.
- R4: When `vbus_valid_i` differs from stored bit 5 at a clock edge, bit 5 takes the new value on that edge. `vbus_chg_o` is high for the cycle that follows that edge.
- R5: When `vbus_valid_i` equals the stored bit 5, `vbus_chg_o` stays 0.
- R6: Bit 5 of `stat_rdata_o` reads 0 whenever `vbus_det_en_i` is 0, with no clock delay. The enable has no effect on the stored bit or on `vbus_chg_o`.
- R7: Bit 8 (power/clock good) reads 1 from the first clock edge after reset release.
- R8: A change on `session_i` does not raise `vbus_chg_o`.
- R9: Bits 31:9 of `stat_rdata_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_valid_i | input | 1 | VBUS-valid level from the USB core |
| session_i | input | 1 | Session-active level from the USB core |
| vbus_det_en_i | input | 1 | Power-management VBUS-detect enable, masks bit 5 on read |
| line_state_i | input | 2 | Bus line state |
| host_discon_i | input | 1 | Host-disconnect level |
| id_status_i | input | 1 | ID pin status, 0 means host |
| vbus_sense_i | input | 1 | VBUS-sense level |
| stat_rdata_o | output | 32 | Status word for register reads |
| vbus_chg_o | output | 1 | One-cycle VBUS-sense-change request |

## Verification
A stored VBUS-valid bit that drifts from the core's level shows up in one of two ways. Either a request pulse appears one cycle after an edge at which the input did not change, or no pulse appears after an edge at which it did. Both are visible on `vbus_chg_o` within a single cycle. A broken session pair shows at bits 6 and 7 on the read port one edge after `session_i` moves. A wrong enable path shows at bit 5 without any clock delay. A misplaced pass-through bit appears at the wrong word position one edge after stimulus.

// File: rtl/otg_status_tracker.sv
`timescale 1ns/1ps
module otg_status_tracker #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbus_valid_i,
  input  logic              session_i,
  input  logic              vbus_det_en_i,
  input  logic [1:0]        line_state_i,
  input  logic              host_discon_i,
  input  logic              id_status_i,
  input  logic              vbus_sense_i,
  output logic [STAT_W-1:0] stat_rdata_o,
  output logic              vbus_chg_o
);
  localparam int VBUS_BIT = 5;
  localparam int LIVE_W   = 9;

  logic [LIVE_W-1:0] stat_q;
  logic              chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      stat_q <= {1'b1, ~session_i, session_i, vbus_valid_i, vbus_sense_i,
                 id_status_i, host_discon_i, line_state_i};
      chg_q  <= (vbus_valid_i != stat_q[VBUS_BIT]);
    end
  end

  logic [LIVE_W-1:0] view;
  assign view = {stat_q[LIVE_W-1:VBUS_BIT+1],
                 stat_q[VBUS_BIT] & vbus_det_en_i,
                 stat_q[VBUS_BIT-1:0]};

  assign stat_rdata_o = {{(STAT_W-LIVE_W){1'b0}}, view};
  assign vbus_chg_o   = chg_q;

  AST_SESS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_rdata_o[6] != stat_rdata_o[7])); // R3
  AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_valid_i != stat_q[VBUS_BIT]) |=> vbus_chg_o); // R4
  AST_NO_CHG_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_valid_i == stat_q[VBUS_BIT]) |=> !vbus_chg_o); // R5
  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_det_en_i |-> !stat_rdata_o[VBUS_BIT]); // R6
  AST_PWR_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_rdata_o[8]); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata_o[STAT_W-1:LIVE_W] == '0); // R9
endmodule

// File: tb/otg_status_tracker_tb.sv
`timescale 1ns/1ps
module otg_status_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vbus_valid_i = 1'b0, session_i = 1'b0, vbus_det_en_i = 1'b1;
  logic [1:0]  line_state_i = 2'b00;
  logic        host_discon_i = 1'b0, id_status_i = 1'b0, vbus_sense_i = 1'b0;
  logic [31:0] stat_rdata_o;
  logic        vbus_chg_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  otg_status_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .vbus_valid_i(vbus_valid_i), .session_i(session_i),
    .vbus_det_en_i(vbus_det_en_i), .line_state_i(line_state_i),
    .host_discon_i(host_discon_i), .id_status_i(id_status_i),
    .vbus_sense_i(vbus_sense_i), .stat_rdata_o(stat_rdata_o), .vbus_chg_o(vbus_chg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] word(input logic vb, input logic ss, input logic en);
    return {23'd0, 1'b1, ~ss, ss, vb & en, vbus_sense_i, id_status_i,
            host_discon_i, line_state_i};
  endfunction

  task automatic t_reset();
    vbus_valid_i = 1; session_i = 1; line_state_i = 2'b11; id_status_i = 1;
    step(); step();
    chk("R1 word in reset", stat_rdata_o, 32'h0);
    chk("R1 request in reset", {31'd0, vbus_chg_o}, 32'h0);
    vbus_valid_i = 0; session_i = 0; line_state_i = 2'b00; id_status_i = 0;
    @(negedge clk); rst_n = 1;
    step();
    chk("R7 power good after release", {31'd0, stat_rdata_o[8]}, 32'h1);
    chk("R1 host mode id=0", {31'd0, stat_rdata_o[3]}, 32'h0);
    chk("R3 session end after release", stat_rdata_o, word(0, 0, 1));
  endtask

  task automatic t_passthru();
    line_state_i = 2'b10; host_discon_i = 1; id_status_i = 0; vbus_sense_i = 1;
    step();
    chk("R2 pattern a", stat_rdata_o, 32'h0000_0196);
    line_state_i = 2'b01; host_discon_i = 0; id_status_i = 1; vbus_sense_i = 0;
    step();
    chk("R2 pattern b", stat_rdata_o, 32'h0000_0189);
    chk("R9 upper zero", {9'd0, stat_rdata_o[31:9]}, 32'h0);
  endtask

  task automatic t_vbus();
    vbus_valid_i = 1; step();
    chk("R4 rise pulse", {31'd0, vbus_chg_o}, 32'h1);
    chk("R4 rise stored", stat_rdata_o, word(1, 0, 1));
    step();
    chk("R5 hold no pulse", {31'd0, vbus_chg_o}, 32'h0);
    step();
    chk("R5 hold no pulse again", {31'd0, vbus_chg_o}, 32'h0);
    vbus_valid_i = 0; step();
    chk("R4 fall pulse", {31'd0, vbus_chg_o}, 32'h1);
    chk("R4 fall stored", stat_rdata_o, word(0, 0, 1));
    vbus_valid_i = 1; step();
    chk("R4 back-to-back pulse", {31'd0, vbus_chg_o}, 32'h1);
    step();
    chk("R5 settled", {31'd0, vbus_chg_o}, 32'h0);
  endtask

  task automatic t_gate();
    vbus_det_en_i = 0; #1;
    chk("R6 masked read", {31'd0, stat_rdata_o[5]}, 32'h0);
    vbus_valid_i = 0; step();
    chk("R6 pulse while masked", {31'd0, vbus_chg_o}, 32'h1);
    vbus_valid_i = 1; step();
    chk("R6 masked after rise", stat_rdata_o, word(1, 0, 0));
    vbus_det_en_i = 1; #1;
    chk("R6 stored bit kept", {31'd0, stat_rdata_o[5]}, 32'h1);
    step();
  endtask

  task automatic t_session();
    session_i = 1; step();
    chk("R3 session valid", stat_rdata_o, word(1, 1, 1));
    chk("R8 no pulse on session rise", {31'd0, vbus_chg_o}, 32'h0);
    session_i = 0; step();
    chk("R3 session end", stat_rdata_o, word(1, 0, 1));
    chk("R8 no pulse on session fall", {31'd0, vbus_chg_o}, 32'h0);
  endtask

  task automatic t_rereset();
    @(negedge clk); rst_n = 0; #1;
    chk("R1 async reset word", stat_rdata_o, 32'h0);
    chk("R1 async reset request", {31'd0, vbus_chg_o}, 32'h0);
    @(negedge clk); rst_n = 1;
    step();
    chk("R4 pulse after reset with vbus high", {31'd0, vbus_chg_o}, 32'h1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_passthru();
    t_vbus();
    t_gate();
    t_session();
    t_rereset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule